// File: doc/BRIEF.md
# Key-protected watchdog interval timer

An 8-bit up-counter sits behind a small memory-mapped register port and advances on a tick from a programmable prescaler. When it wraps from 0xFF to 0x00 it does one of two things, chosen by a mode bit. In watchdog mode it drives a reset request for a fixed number of clock cycles. In interval mode it latches an overflow flag that drives an interrupt line.

Software guards against stray writes in two ways. A register changes only on a 16-bit write whose upper byte carries that register's own key. All other write sizes have no effect. Reads are single bytes.

Both registers return to zero only through the power-on reset input. The chip reset controller and the interrupt controller use the two outputs. Neither controller is part of this block.

Top module: `wdt_keyed_timer`

## Requirements
- R1: After power-on reset the counter reads 0x00, the control register reads 0x00, and both `irq` and `rst_req` are low.
- R2: A 16-bit write (size code 1) to offset 0x8 loads the low data byte into the counter only when data bits 15:8 equal 0x5A. Any other upper byte leaves the counter unchanged.
- R3: A 16-bit write to offset 0xC updates the control register only when data bits 15:8 equal 0xA5. The control byte has these fields:
  - bit 7: enable
  - bit 6: mode (1 = watchdog, 0 = interval)
  - bit 5: overflow flag. Writing 0 clears it; writing 1 leaves it as it is.
  - bits 2:0: clock select
  - bits 4:3: read as 0
- R4: Writes with size code 0 (8-bit) or size code 2 (32-bit) change neither register, whatever their data.
- R5: A read with size code 0 at offset 0x8 or 0xC returns that register on `bus_rdata`. Reads of any other size or offset return 0x00.
- R6: Clock-select codes 0 to 7 divide by 1, 4, 16, 32, 64, 256, 1024 and 4096. The enabling write takes effect at edge 0. After k further edges the counter has advanced by k divided by the ratio, rounded down.
- R7: While the enable bit is 0 the prescaler is held at zero and the counter does not move.
- R8: A wrap from 0xFF to 0x00 sets the overflow flag. In interval mode `irq` is high from the edge after the wrap until a keyed control write clears the flag.
- R9: A wrap in watchdog mode drives `rst_req` high for exactly RST_CYCLES (16) cycles, starting at the wrap edge. `irq` stays low in watchdog mode.
- R10: If a keyed counter write lands on the same edge as a count tick, the written value wins and no overflow is recorded, even when the counter holds 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| bus_sel | input | 1 | Access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Register offset |
| bus_size | input | 2 | Access size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| bus_wdata | input | 16 | Write data: key in bits 15:8, value in bits 7:0 |
| bus_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Interval-mode overflow interrupt, level |
| rst_req | output | 1 | Watchdog reset request pulse |

## Verification
A software counter write can land on the same edge as the prescaler tick that would wrap the counter from 0xFF. The bench provokes this by loading 0xFE at divide-by-1 and enabling the timer. It then issues a keyed counter write timed to reach the counter on the second edge, when 0xFF would roll over. The result is judged at the ports: the counter must read the written value, `irq` must stay low, and the control byte must show no overflow flag. The checker also asserts that the counter holds the written byte after any edge on which a write and a tick coincide.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // access size codes on bus_size
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // per-register write keys carried in data bits 15:8
  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [7:0] KEY_CSR = 8'hA5;

  typedef struct packed {
    logic       en;
    logic       wdog;
    logic       flag;
    logic [2:0] sel;
  } ctl_t;

  // log2 of the divide ratio chosen by the clock-select code
  function automatic logic [3:0] div_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 4'd0;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd5;
      3'd4:    return 4'd6;
      3'd5:    return 4'd8;
      3'd6:    return 4'd10;
      default: return 4'd12;
    endcase
  endfunction

  // visible byte of the control register
  function automatic logic [7:0] ctl_pack(input ctl_t c);
    return {c.en, c.wdog, c.flag, 2'b00, c.sel};
  endfunction

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
  import wdt_pkg::*;
#(
  parameter int              ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] CNT_OFS = 4'h8,
  parameter logic [ADDR_W-1:0] CSR_OFS = 4'hC
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic              cnt_wr,
  output logic              csr_wr,
  output logic [7:0]        wr_byte,
  output logic              rd_cnt,
  output logic              rd_csr
);

  logic half_wr;
  logic byte_rd;
  logic [7:0] key;

  assign key     = bus_wdata[15:8];
  assign wr_byte = bus_wdata[7:0];
  assign half_wr = bus_sel & bus_wr & (bus_size == SZ_HALF);
  assign byte_rd = bus_sel & ~bus_wr & (bus_size == SZ_BYTE);

  assign cnt_wr = half_wr & (bus_addr == CNT_OFS) & (key == KEY_CNT);
  assign csr_wr = half_wr & (bus_addr == CSR_OFS) & (key == KEY_CSR);
  assign rd_cnt = byte_rd & (bus_addr == CNT_OFS);
  assign rd_csr = byte_rd & (bus_addr == CSR_OFS);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = (PRE_W'(1) << div_shift(sel)) - PRE_W'(1);
  assign tick = run & ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   pre_q <= '0;
    else if (run) pre_q <= pre_q + PRE_W'(1);
    else          pre_q <= '0;
  end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);

  // a load on the same edge as a tick takes priority and cancels the wrap
  assign wrap = tick & ~load & (cnt_q == {W{1'b1}});

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic req
);

  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q;

  assign req = (left_q != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      left_q <= '0;
    else if (trig)   left_q <= CW'(LEN);
    else if (req)    left_q <= left_q - CW'(1);
  end

endmodule

// File: rtl/wdt_keyed_timer.sv
module wdt_keyed_timer
  import wdt_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] CNT_OFS    = 4'h8,
  parameter logic [ADDR_W-1:0] CSR_OFS    = 4'hC,
  parameter int                PRE_W      = 12,
  parameter int                RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              rst_req
);

  localparam int CNT_W = 8;

  // named internal events, also observed by the bound checker
  logic             cnt_wr;
  logic             csr_wr;
  logic [7:0]       wr_byte;
  logic             rd_cnt;
  logic             rd_csr;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  ctl_t             ctl_q;
  logic             unused_rsvd;

  assign unused_rsvd = ^wr_byte[4:3];

  wdt_bus_decode #(
    .ADDR_W (ADDR_W),
    .CNT_OFS(CNT_OFS),
    .CSR_OFS(CSR_OFS)
  ) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata),
    .cnt_wr   (cnt_wr),
    .csr_wr   (csr_wr),
    .wr_byte  (wr_byte),
    .rd_cnt   (rd_cnt),
    .rd_csr   (rd_csr)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .por_n(por_n),
    .run  (ctl_q.en),
    .sel  (ctl_q.sel),
    .tick (tick)
  );

  wdt_count #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .por_n   (por_n),
    .tick    (tick),
    .load    (cnt_wr),
    .load_val(wr_byte),
    .cnt_q   (cnt_q),
    .wrap    (wrap)
  );

  wdt_rst_pulse #(.LEN(RST_CYCLES)) u_rst (
    .clk  (clk),
    .por_n(por_n),
    .trig (wrap & ctl_q.wdog),
    .req  (rst_req)
  );

  // control register; a new wrap outranks a flag clear on the same edge
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctl_q <= '0;
    end else begin
      if (csr_wr) begin
        ctl_q.en   <= wr_byte[7];
        ctl_q.wdog <= wr_byte[6];
        ctl_q.sel  <= wr_byte[2:0];
      end
      if (wrap)        ctl_q.flag <= 1'b1;
      else if (csr_wr) ctl_q.flag <= ctl_q.flag & wr_byte[5];
    end
  end

  assign irq = ctl_q.flag & ~ctl_q.wdog;

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_cnt)      bus_rdata = cnt_q;
    else if (rd_csr) bus_rdata = ctl_pack(ctl_q);
  end

endmodule

// File: rtl/wdt_keyed_timer_chk.sv
module wdt_keyed_timer_chk
  import wdt_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_size,
  input logic       run,
  input logic       wdog,
  input logic       tick,
  input logic       wrap,
  input logic       cnt_wr,
  input logic [7:0] wr_byte,
  input logic [7:0] cnt_q,
  input logic       irq,
  input logic       rst_req
);

  // R7: counter frozen while disabled and not written
  p_frozen_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!run && !cnt_wr) |=> $stable(cnt_q));

  // R8: wrap leaves the counter at zero
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!por_n)
    wrap |=> (cnt_q == 8'h00));

  // R8: interval-mode wrap raises the interrupt
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!por_n)
    (wrap && !wdog) |=> irq);

  // R9: watchdog-mode wrap starts the reset request
  p_rst_start_r9: assert property (@(posedge clk) disable iff (!por_n)
    (wrap && wdog) |=> rst_req);

  // R4: non-16-bit writes never move the counter
  p_size_filter_r4: assert property (@(posedge clk) disable iff (!por_n)
    (bus_sel && bus_wr && bus_size != SZ_HALF && !tick) |=> $stable(cnt_q));

  // R10: a write coinciding with a tick wins
  p_collide_r10: assert property (@(posedge clk) disable iff (!por_n)
    (cnt_wr && tick) |=> (cnt_q == $past(wr_byte)));

endmodule

bind wdt_keyed_timer wdt_keyed_timer_chk u_chk (
  .clk     (clk),
  .por_n   (por_n),
  .bus_sel (bus_sel),
  .bus_wr  (bus_wr),
  .bus_size(bus_size),
  .run     (ctl_q.en),
  .wdog    (ctl_q.wdog),
  .tick    (tick),
  .wrap    (wrap),
  .cnt_wr  (cnt_wr),
  .wr_byte (wr_byte),
  .cnt_q   (cnt_q),
  .irq     (irq),
  .rst_req (rst_req)
);

// File: tb/wdt_keyed_timer_bench.sv
`timescale 1ns/1ps
module wdt_keyed_timer_bench;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [15:0] bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_CNT = 4'h8;
  localparam logic [3:0] A_CSR = 4'hC;

  always #2 clk = ~clk;

  wdt_keyed_timer u_wdt_keyed_timer (
    .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  // {sel[2:0], start[7:0], edges[15:0], expected[7:0]}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 8'h10, 16'd5,    8'h15},
    {3'd1, 8'h20, 16'd7,    8'h21},
    {3'd2, 8'h00, 16'd40,   8'h02},
    {3'd3, 8'h00, 16'd100,  8'h03},
    {3'd4, 8'h00, 16'd130,  8'h02},
    {3'd5, 8'h00, 16'd600,  8'h02},
    {3'd6, 8'h00, 16'd2100, 8'h02},
    {3'd7, 8'h00, 16'd8200, 8'h02}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_edges(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic summary_dummy();
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(A_CNT, 2'd0, v); chk("R1 counter", v, 8'h00);
    rd(A_CSR, 2'd0, v); chk("R1 control", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rst_req", {7'd0, rst_req}, 8'h00);

    // R6: table of divide ratios
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  s;
      logic [7:0]  st;
      logic [15:0] ed;
      logic [7:0]  ex;
      {s, st, ed, ex} = VEC[i];
      wr(A_CSR, 2'd1, 16'hA500);
      wr(A_CNT, 2'd1, {8'h5A, st});
      wr(A_CSR, 2'd1, {8'hA5, 5'b10000, s});
      wait_edges(int'(ed));
      rd(A_CNT, 2'd0, v); chk("R6 divided count", v, ex);
    end

    // R3: control readback, reserved bits read 0
    wr(A_CSR, 2'd1, 16'hA5_1B);
    rd(A_CSR, 2'd0, v); chk("R3 control readback", v, 8'h03);

    // R2 / R4 / R3 key and size filters, timer disabled
    wr(A_CSR, 2'd1, 16'hA500);
    wr(A_CNT, 2'd1, 16'h5A33);
    rd(A_CNT, 2'd0, v); chk("R2 keyed load", v, 8'h33);
    wr(A_CNT, 2'd1, 16'hA577);
    rd(A_CNT, 2'd0, v); chk("R2 wrong key", v, 8'h33);
    wr(A_CNT, 2'd0, 16'h5A77);
    rd(A_CNT, 2'd0, v); chk("R4 byte write", v, 8'h33);
    wr(A_CNT, 2'd2, 16'h5A77);
    rd(A_CNT, 2'd0, v); chk("R4 word write", v, 8'h33);
    wr(A_CSR, 2'd0, 16'hA580);
    rd(A_CSR, 2'd0, v); chk("R4 byte write control", v, 8'h00);
    wr(A_CSR, 2'd1, 16'h5A80);
    rd(A_CSR, 2'd0, v); chk("R3 wrong key", v, 8'h00);

    // R5: non-byte read returns zero
    rd(A_CNT, 2'd1, v); chk("R5 half read", v, 8'h00);
    rd(4'h4, 2'd0, v);  chk("R5 other offset", v, 8'h00);

    // R7: disabled counter frozen
    wait_edges(50);
    rd(A_CNT, 2'd0, v); chk("R7 frozen", v, 8'h33);

    // R8: interval overflow
    wr(A_CNT, 2'd1, 16'h5AFE);
    wr(A_CSR, 2'd1, 16'hA580);
    wait_edges(1);
    chk("R8 no irq before wrap", {7'd0, irq}, 8'h00);
    wait_edges(1);
    chk("R8 irq after wrap", {7'd0, irq}, 8'h01);
    rd(A_CNT, 2'd0, v); chk("R8 counter wrapped", v, 8'h00);
    rd(A_CSR, 2'd0, v); chk("R8 flag set", v, 8'hA0);
    wr(A_CSR, 2'd1, 16'hA5A0);
    chk("R3 writing flag 1 keeps it", {7'd0, irq}, 8'h01);
    wr(A_CSR, 2'd1, 16'hA500);
    chk("R8 irq cleared", {7'd0, irq}, 8'h00);
    rd(A_CSR, 2'd0, v); chk("R8 flag cleared", v, 8'h00);

    // R9: watchdog pulse length
    wr(A_CNT, 2'd1, 16'h5AFF);
    wr(A_CSR, 2'd1, 16'hA5C0);
    wait_edges(1);
    chk("R9 rst_req starts", {7'd0, rst_req}, 8'h01);
    chk("R9 irq low", {7'd0, irq}, 8'h00);
    wait_edges(15);
    chk("R9 rst_req last cycle", {7'd0, rst_req}, 8'h01);
    wait_edges(1);
    chk("R9 rst_req ended", {7'd0, rst_req}, 8'h00);
    wr(A_CSR, 2'd1, 16'hA500);

    // R10: write collides with wrapping tick
    wr(A_CNT, 2'd1, 16'h5AFE);
    wr(A_CSR, 2'd1, 16'hA580);
    wr(A_CNT, 2'd1, 16'h5A10);
    rd(A_CNT, 2'd0, v); chk("R10 write wins", v, 8'h10);
    chk("R10 no irq", {7'd0, irq}, 8'h00);
    rd(A_CSR, 2'd0, v); chk("R10 no flag", v, 8'h80);
    wr(A_CSR, 2'd1, 16'hA500);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule